// File: doc/BRIEF.md
# Single-Wire Slave Transaction Sequencer

This block is the transaction-layer state machine of a slave on a single-wire bus. It sits above a bit-level transceiver. The transceiver reports a detected bus reset, hands over each received byte, and asks for the next byte to send. The sequencer answers each reset with a request for a presence pulse. It then expects one identity-layer command, and only after that one function command. If a step is skipped, a code is not recognised, or an identity match fails, the slave drops off the bus until the next reset.

The sequencer holds a 64-bit identity. The low byte is a family code (28h by default), the next 48 bits are a serial number, and the top byte is a CRC of the lower 56 bits. It can send that identity, or compare the master's address against it byte by byte. The two search commands are only sequenced here: the block flags a search start, and the search itself belongs to a neighbour. The alarm variant of search is flagged only when the integer part of the temperature lies outside the limits. Once a function command is accepted, the bus belongs to the function layer until the next reset.

Top module: `owseq_top`

## Requirements
- R1: A one-cycle `bus_rst_i` pulse, seen in any state, gives a one-cycle `presence_o` pulse in the cycle after it and reopens the identity-command step.
- R2: Out of reset, and while idle, received bytes give no function, transmit or search activity until a bus reset has been seen.
- R3: A byte that is not one of the identity codes 33h, 55h, CCh, F0h or ECh, received as the first byte after presence (a function code included), sends the block idle. Later bytes are ignored until a reset.
- R4: Read (33h) raises `tx_vld_o` and offers the eight identity bytes, least significant byte first, one per `tx_take_i` pulse. Byte 0 is the family code, bytes 1 to 6 are the serial number low byte first, and byte 7 is the CRC. After the eighth byte is taken, a function command is accepted.
- R5: The CRC byte is the CRC-8 with polynomial x^8+x^5+x^4+1, initial value 0, over the 56 family and serial bits fed least significant bit first.
- R6: Match (55h) compares the next eight received bytes with the identity, in the same byte order as R4. If all eight are equal, a function command is accepted. On the first unequal byte the block goes idle until a reset.
- R7: Skip (CCh) moves straight to the function-command step.
- R8: Search (F0h) gives one `search_go_o` pulse with `search_alm_o` = 0. Afterwards no function command is accepted until a reset.
- R9: Alarm search (ECh) gives a `search_go_o` pulse with `search_alm_o` = 1 only when temp_i>>>4 (signed) is greater than the signed `hi_lim_i` or less than the signed `lo_lim_i`. Otherwise there is no pulse. In both cases, later bytes are ignored until a reset.
- R10: In the function step, codes 44h, BEh, 4Eh, 48h, B8h and B4h give a one-cycle `fn_cmd_vld_o` with the code on `fn_cmd_o` in the cycle after the byte, and raise `fn_open_o` until the next reset. Any other code sends the block idle. Bytes received while `fn_open_o` is high are not reported as commands.
- R11: A reset in the middle of a transaction aborts it: `tx_vld_o` and `fn_open_o` are low in the cycle after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | Bus reset detected by the transceiver (one-cycle pulse) |
| rx_vld_i | input | 1 | Received byte valid |
| rx_byte_i | input | 8 | Received byte |
| tx_take_i | input | 1 | Transceiver consumes the offered byte |
| temp_i | input | TEMP_W | Signed temperature, FRAC_W fraction bits |
| hi_lim_i | input | LIM_W | Signed upper alarm limit, whole degrees |
| lo_lim_i | input | LIM_W | Signed lower alarm limit, whole degrees |
| presence_o | output | 1 | Request a presence pulse |
| tx_vld_o | output | 1 | A byte is offered for sending |
| tx_byte_o | output | 8 | Offered byte |
| fn_cmd_vld_o | output | 1 | Function command accepted (one cycle) |
| fn_cmd_o | output | 8 | Accepted function code |
| fn_open_o | output | 1 | Function layer owns the bus |
| search_go_o | output | 1 | Start a search (one cycle) |
| search_alm_o | output | 1 | The search started is the alarm variant |

## Verification
The bench targets the ordering rules. It sends a function code before any reset and in the identity slot, a wrong address byte in the middle of a match, and function bytes after each search. A sequencer that skipped any of these gates would report a function command that should never appear. It also checks the identity bytes and their CRC against its own computation, so a byte-order or polynomial error shows up as a wrong transmit byte. The alarm gate is tried with temperatures above, inside and below the limits, negative values included. A reset in the middle of a send checks that transmission stops, where a design without an abort path would keep offering bytes.

// File: rtl/owseq_pkg.sv
package owseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_PRES, ST_ROM, ST_SEND, ST_MATCH, ST_FNCMD, ST_FNOPEN
   } seq_st_t;

   typedef enum logic [2:0] {
      RC_NONE, RC_READ, RC_MATCH, RC_SKIP, RC_SEARCH, RC_ASEARCH
   } rom_cls_t;

   localparam logic [7:0] OP_READ    = 8'h33;
   localparam logic [7:0] OP_MATCH   = 8'h55;
   localparam logic [7:0] OP_SKIP    = 8'hCC;
   localparam logic [7:0] OP_SEARCH  = 8'hF0;
   localparam logic [7:0] OP_ASEARCH = 8'hEC;

   localparam logic [7:0] OP_CONVERT = 8'h44;
   localparam logic [7:0] OP_RDPAD   = 8'hBE;
   localparam logic [7:0] OP_WRPAD   = 8'h4E;
   localparam logic [7:0] OP_COPY    = 8'h48;
   localparam logic [7:0] OP_RECALL  = 8'hB8;
   localparam logic [7:0] OP_PWR     = 8'hB4;

   // reflected CRC-8 (x^8+x^5+x^4+1), bits consumed LSB first
   function automatic logic [7:0] crc8_lsb(input logic [63:0] data, input int nbits);
      logic [7:0] c;
      logic       mix;
      c = '0;
      for (int i = 0; i < 64; i++) begin
         if (i < nbits) begin
            mix = c[0] ^ data[i];
            c   = c >> 1;
            if (mix) c = c ^ 8'h8C;
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/owseq_id_rom.sv
module owseq_id_rom
   import owseq_pkg::*;
#(
   parameter int          FAMILY_W  = 8,
   parameter int          SERIAL_W  = 48,
   parameter int          CRC_W     = 8,
   parameter logic [7:0]  FAMILY    = 8'h28,
   parameter logic [47:0] SERIAL    = 48'h0000_1A2B_3C4D,
   parameter bit          CRC_AUTO  = 1'b1,
   parameter logic [7:0]  CRC_FIXED = 8'h00,
   parameter int          IDX_W     = 3
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic [7:0]       byte_o
);
   localparam int ID_BITS = FAMILY_W + SERIAL_W + CRC_W;
   localparam int NBYTES  = ID_BITS / 8;

   if (ID_BITS != 64 || FAMILY_W != 8 || CRC_W != 8) begin : g_bad_layout
      $error("owseq_id_rom: identity must be 8+48+8 bits");
   end
   if ((1 << IDX_W) != NBYTES) begin : g_bad_idx
      $error("owseq_id_rom: IDX_W must address exactly NBYTES");
   end

   logic [7:0]  crc_val;
   logic [63:0] id_word;

   if (CRC_AUTO) begin : g_crc_calc
      assign crc_val = crc8_lsb({8'h00, SERIAL, FAMILY}, FAMILY_W + SERIAL_W);
   end else begin : g_crc_fixed
      assign crc_val = CRC_FIXED;
   end

   assign id_word = {crc_val, SERIAL, FAMILY};

   logic [7:0] id_bytes [NBYTES];
   for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
      assign id_bytes[g] = id_word[g*8 +: 8];
   end

   assign byte_o = id_bytes[idx_i];

endmodule

// File: rtl/owseq_cnt.sv
module owseq_cnt #(
   parameter int COUNT = 8,
   localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             last_o
);
   if (COUNT < 2) begin : g_bad_count
      $error("owseq_cnt: COUNT must be at least 2");
   end

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (clr_i)  idx_q <= '0;
      else if (inc_i)  idx_q <= idx_q + 1'b1;
   end

   assign idx_o  = idx_q;
   assign last_o = (idx_q == IDX_W'(COUNT - 1));

   // the sequencer must leave the byte loop on the last byte instead of stepping past it
   assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i) |-> !last_o);

endmodule

// File: rtl/owseq_decode.sv
module owseq_decode
   import owseq_pkg::*;
(
   input  logic [7:0] cmd_i,
   output rom_cls_t   rom_cls_o,
   output logic       fn_known_o
);
   always_comb begin
      unique case (cmd_i)
         OP_READ:    rom_cls_o = RC_READ;
         OP_MATCH:   rom_cls_o = RC_MATCH;
         OP_SKIP:    rom_cls_o = RC_SKIP;
         OP_SEARCH:  rom_cls_o = RC_SEARCH;
         OP_ASEARCH: rom_cls_o = RC_ASEARCH;
         default:    rom_cls_o = RC_NONE;
      endcase
   end

   always_comb begin
      unique case (cmd_i)
         OP_CONVERT, OP_RDPAD, OP_WRPAD,
         OP_COPY, OP_RECALL, OP_PWR: fn_known_o = 1'b1;
         default:                    fn_known_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/owseq_alarm.sv
module owseq_alarm #(
   parameter int TEMP_W = 16,
   parameter int FRAC_W = 4,
   parameter int LIM_W  = 8
) (
   input  logic [TEMP_W-1:0] temp_i,
   input  logic [LIM_W-1:0]  hi_i,
   input  logic [LIM_W-1:0]  lo_i,
   output logic              alarm_o
);
   if (TEMP_W <= LIM_W) begin : g_bad_width
      $error("owseq_alarm: TEMP_W must exceed LIM_W");
   end

   logic signed [TEMP_W-1:0] t_int;
   logic signed [TEMP_W-1:0] hi_ext;
   logic signed [TEMP_W-1:0] lo_ext;

   if (FRAC_W == 0) begin : g_whole
      assign t_int = $signed(temp_i);
   end else begin : g_frac
      assign t_int = $signed(temp_i) >>> FRAC_W;
   end

   assign hi_ext  = $signed({{(TEMP_W-LIM_W){hi_i[LIM_W-1]}}, hi_i});
   assign lo_ext  = $signed({{(TEMP_W-LIM_W){lo_i[LIM_W-1]}}, lo_i});
   assign alarm_o = (t_int > hi_ext) || (t_int < lo_ext);

endmodule

// File: rtl/owseq_top.sv
module owseq_top
   import owseq_pkg::*;
#(
   parameter logic [7:0]  FAMILY_CODE = 8'h28,
   parameter logic [47:0] SERIAL_NUM  = 48'h0000_1A2B_3C4D,
   parameter bit          CRC_AUTO    = 1'b1,
   parameter logic [7:0]  CRC_FIXED   = 8'h00,
   parameter int          TEMP_W      = 16,
   parameter int          FRAC_W      = 4,
   parameter int          LIM_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst_i,
   input  logic              rx_vld_i,
   input  logic [7:0]        rx_byte_i,
   input  logic              tx_take_i,
   input  logic [TEMP_W-1:0] temp_i,
   input  logic [LIM_W-1:0]  hi_lim_i,
   input  logic [LIM_W-1:0]  lo_lim_i,
   output logic              presence_o,
   output logic              tx_vld_o,
   output logic [7:0]        tx_byte_o,
   output logic              fn_cmd_vld_o,
   output logic [7:0]        fn_cmd_o,
   output logic              fn_open_o,
   output logic              search_go_o,
   output logic              search_alm_o
);
   localparam int FAMILY_W = 8;
   localparam int SERIAL_W = 48;
   localparam int CRC_W    = 8;
   localparam int ID_BITS  = FAMILY_W + SERIAL_W + CRC_W;
   localparam int NBYTES   = ID_BITS / 8;
   localparam int IDX_W    = $clog2(NBYTES);

   seq_st_t          st_q, st_d;
   rom_cls_t         rom_cls;
   logic             fn_known;
   logic [7:0]       id_byte;
   logic [IDX_W-1:0] idx;
   logic             idx_last;
   logic             alarm;
   logic             cnt_clr, cnt_inc;
   logic             fn_vld_d, fn_vld_q;
   logic [7:0]       fn_cmd_q;
   logic             srch_d, srch_q, srch_alm_d, srch_alm_q;

   owseq_decode u_dec (
      .cmd_i      (rx_byte_i),
      .rom_cls_o  (rom_cls),
      .fn_known_o (fn_known)
   );

   owseq_id_rom #(
      .FAMILY_W  (FAMILY_W),
      .SERIAL_W  (SERIAL_W),
      .CRC_W     (CRC_W),
      .FAMILY    (FAMILY_CODE),
      .SERIAL    (SERIAL_NUM),
      .CRC_AUTO  (CRC_AUTO),
      .CRC_FIXED (CRC_FIXED),
      .IDX_W     (IDX_W)
   ) u_id (
      .idx_i  (idx),
      .byte_o (id_byte)
   );

   owseq_cnt #(.COUNT(NBYTES)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (cnt_clr),
      .inc_i  (cnt_inc),
      .idx_o  (idx),
      .last_o (idx_last)
   );

   owseq_alarm #(
      .TEMP_W (TEMP_W),
      .FRAC_W (FRAC_W),
      .LIM_W  (LIM_W)
   ) u_alm (
      .temp_i  (temp_i),
      .hi_i    (hi_lim_i),
      .lo_i    (lo_lim_i),
      .alarm_o (alarm)
   );

   assign cnt_clr = (st_q != ST_SEND) && (st_q != ST_MATCH);

   always_comb begin
      st_d       = st_q;
      cnt_inc    = 1'b0;
      fn_vld_d   = 1'b0;
      srch_d     = 1'b0;
      srch_alm_d = 1'b0;
      if (bus_rst_i) begin
         st_d = ST_PRES;
      end else begin
         unique case (st_q)
            ST_IDLE:   st_d = ST_IDLE;
            ST_PRES:   st_d = ST_ROM;
            ST_ROM: begin
               if (rx_vld_i) begin
                  unique case (rom_cls)
                     RC_READ:  st_d = ST_SEND;
                     RC_MATCH: st_d = ST_MATCH;
                     RC_SKIP:  st_d = ST_FNCMD;
                     RC_SEARCH: begin
                        st_d   = ST_IDLE;
                        srch_d = 1'b1;
                     end
                     RC_ASEARCH: begin
                        st_d       = ST_IDLE;
                        srch_d     = alarm;
                        srch_alm_d = alarm;
                     end
                     default:  st_d = ST_IDLE;
                  endcase
               end
            end
            ST_SEND: begin
               if (tx_take_i) begin
                  if (idx_last) st_d = ST_FNCMD;
                  else          cnt_inc = 1'b1;
               end
            end
            ST_MATCH: begin
               if (rx_vld_i) begin
                  if (rx_byte_i != id_byte) st_d = ST_IDLE;
                  else if (idx_last)        st_d = ST_FNCMD;
                  else                      cnt_inc = 1'b1;
               end
            end
            ST_FNCMD: begin
               if (rx_vld_i) begin
                  if (fn_known) begin
                     st_d     = ST_FNOPEN;
                     fn_vld_d = 1'b1;
                  end else begin
                     st_d = ST_IDLE;
                  end
               end
            end
            ST_FNOPEN: st_d = ST_FNOPEN;
            default:   st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         fn_vld_q   <= 1'b0;
         fn_cmd_q   <= '0;
         srch_q     <= 1'b0;
         srch_alm_q <= 1'b0;
      end else begin
         st_q       <= st_d;
         fn_vld_q   <= fn_vld_d;
         srch_q     <= srch_d;
         srch_alm_q <= srch_alm_d;
         if (fn_vld_d) fn_cmd_q <= rx_byte_i;
      end
   end

   assign presence_o   = (st_q == ST_PRES);
   assign tx_vld_o     = (st_q == ST_SEND);
   assign tx_byte_o    = id_byte;
   assign fn_cmd_vld_o = fn_vld_q;
   assign fn_cmd_o     = fn_cmd_q;
   assign fn_open_o    = (st_q == ST_FNOPEN);
   assign search_go_o  = srch_q;
   assign search_alm_o = srch_alm_q;

   // a presence request only follows a detected bus reset
   assert_pres_after_rst_R1: assert property (@(posedge clk) disable iff (!rst_n)
      presence_o |-> $past(bus_rst_i));

   // a reset in the middle of a transaction stops sending and closes the function layer
   assert_abort_on_rst_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_rst_i) |-> (!tx_vld_o && !fn_open_o));

   // an address byte that differs from the identity drops the slave off the bus
   assert_match_miss_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_q == ST_MATCH && rx_vld_i && !bus_rst_i && rx_byte_i != id_byte)
      |-> (st_q == ST_IDLE));

   // an alarm search start needs an alarm condition the cycle before
   assert_alarm_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (search_go_o && search_alm_o) |-> $past(alarm));

   // search starts and function acceptance never coincide
   assert_search_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(search_go_o && fn_cmd_vld_o));

   // an accepted function command opens the function layer
   assert_fn_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_cmd_vld_o && !$past(bus_rst_i)) |-> fn_open_o);

endmodule

// File: tb/owseq_top_test.sv
module owseq_top_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rst = 1'b0;
   logic        rx_vld = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        tx_take = 1'b0;
   logic [15:0] temp = '0;
   logic [7:0]  hi_lim = 8'd25;
   logic [7:0]  lo_lim = 8'd10;
   logic        presence_o, tx_vld_o, fn_cmd_vld_o, fn_open_o, search_go_o, search_alm_o;
   logic [7:0]  tx_byte_o, fn_cmd_o;

   int errors = 0;
   int checks = 0;
   logic [11:0] exp_q[$];
   string       req_q[$];
   string       cur_req = "R2";
   logic [7:0]  id_ref [8];

   always #(CLK_P/2) clk = ~clk;

   owseq_top uut (
      .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst), .rx_vld_i(rx_vld),
      .rx_byte_i(rx_byte), .tx_take_i(tx_take), .temp_i(temp),
      .hi_lim_i(hi_lim), .lo_lim_i(lo_lim), .presence_o(presence_o),
      .tx_vld_o(tx_vld_o), .tx_byte_o(tx_byte_o), .fn_cmd_vld_o(fn_cmd_vld_o),
      .fn_cmd_o(fn_cmd_o), .fn_open_o(fn_open_o), .search_go_o(search_go_o),
      .search_alm_o(search_alm_o)
   );

   // event kinds: 1 presence, 2 transmitted byte, 3 function command, 4 search start
   task automatic expect_ev(input logic [3:0] kind, input logic [7:0] data, input string req);
      exp_q.push_back({kind, data});
      req_q.push_back(req);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic log_ev(input logic [3:0] kind, input logic [7:0] data);
      logic [11:0] e;
      string r;
      if (exp_q.size() == 0) begin
         checks++;
         errors++;
         $display("FAIL %s unexpected event actual=%0h expected=none", cur_req, {kind, data});
      end else begin
         e = exp_q.pop_front();
         r = req_q.pop_front();
         chk(e == {kind, data}, r, {kind, data}, e);
      end
   endtask

   // monitor: samples just before each rising edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/2 - 1);
         if (rst_n) begin
            if (presence_o)           log_ev(4'd1, 8'h00);
            if (tx_vld_o && tx_take)  log_ev(4'd2, tx_byte_o);
            if (fn_cmd_vld_o)         log_ev(4'd3, fn_cmd_o);
            if (search_go_o)          log_ev(4'd4, {7'b0, search_alm_o});
         end
      end
   end

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk); rx_vld = 1'b1; rx_byte = b;
      @(negedge clk); rx_vld = 1'b0;
   endtask

   task automatic take_byte();
      @(negedge clk); tx_take = 1'b1;
      @(negedge clk); tx_take = 1'b0;
   endtask

   task automatic bus_reset(input string req);
      expect_ev(4'd1, 8'h00, req);
      @(negedge clk); bus_rst = 1'b1;
      @(negedge clk); bus_rst = 1'b0;
   endtask

   task automatic settle(input string req);
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
      exp_q.delete();
      req_q.delete();
   endtask

   function automatic logic [7:0] ref_crc(input logic [55:0] bits);
      logic [7:0] sr = 8'h00;
      logic fb;
      for (int i = 0; i < 56; i++) begin
         fb = sr[0] ^ bits[i];
         sr = {fb, sr[7:1]};
         sr[3] = sr[3] ^ fb;
         sr[2] = sr[2] ^ fb;
      end
      return sr;
   endfunction

   initial begin
      logic [55:0] low56;
      low56 = {48'h0000_1A2B_3C4D, 8'h28};
      for (int i = 0; i < 7; i++) id_ref[i] = low56[i*8 +: 8];
      id_ref[7] = ref_crc(low56);
   end

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // reset state (R2)
      chk(!presence_o && !tx_vld_o && !fn_cmd_vld_o && !fn_open_o && !search_go_o,
          "R2", {presence_o, tx_vld_o, fn_cmd_vld_o, fn_open_o, search_go_o}, 0);
      rst_n = 1'b1;

      // R2: bytes before any bus reset are ignored
      cur_req = "R2";
      send_byte(8'hCC); send_byte(8'h44);
      settle("R2");
      chk(!fn_open_o, "R2", fn_open_o, 0);

      // R1, R7, R10: skip then convert; further bytes belong to the function layer
      cur_req = "R7";
      bus_reset("R1");
      send_byte(8'hCC);
      expect_ev(4'd3, 8'h44, "R7");
      send_byte(8'h44);
      send_byte(8'hBE);
      settle("R10");
      chk(fn_open_o, "R10", fn_open_o, 1);

      // R4, R5: read identity then read scratchpad
      cur_req = "R4";
      bus_reset("R1");
      chk(!fn_open_o, "R11", fn_open_o, 0);
      send_byte(8'h33);
      chk(tx_vld_o, "R4", tx_vld_o, 1);
      for (int i = 0; i < 8; i++) begin
         expect_ev(4'd2, id_ref[i], (i == 7) ? "R5" : "R4");
         take_byte();
      end
      chk(!tx_vld_o, "R4", tx_vld_o, 0);
      expect_ev(4'd3, 8'hBE, "R4");
      send_byte(8'hBE);
      settle("R4");

      // R6: correct match
      cur_req = "R6";
      bus_reset("R1");
      send_byte(8'h55);
      for (int i = 0; i < 8; i++) send_byte(id_ref[i]);
      expect_ev(4'd3, 8'h4E, "R6");
      send_byte(8'h4E);
      settle("R6");

      // R6: mismatch on byte 3 drops off the bus
      bus_reset("R1");
      send_byte(8'h55);
      for (int i = 0; i < 8; i++) send_byte((i == 3) ? (id_ref[i] ^ 8'h01) : id_ref[i]);
      send_byte(8'h44);
      settle("R6");
      chk(!fn_open_o, "R6", fn_open_o, 0);

      // R3: function code in the identity slot
      cur_req = "R3";
      bus_reset("R1");
      send_byte(8'h44); send_byte(8'hCC); send_byte(8'h44);
      settle("R3");
      chk(!fn_open_o, "R3", fn_open_o, 0);

      // R10: unknown function code
      cur_req = "R10";
      bus_reset("R1");
      send_byte(8'hCC); send_byte(8'h12); send_byte(8'h44);
      settle("R10");
      chk(!fn_open_o, "R10", fn_open_o, 0);

      // R8: search then a function byte
      cur_req = "R8";
      bus_reset("R1");
      expect_ev(4'd4, 8'h00, "R8");
      send_byte(8'hF0); send_byte(8'h44);
      settle("R8");

      // R9: alarm search, above upper limit (30 C, limits 10..25)
      cur_req = "R9";
      temp = 16'h01E0;
      bus_reset("R1");
      expect_ev(4'd4, 8'h01, "R9");
      send_byte(8'hEC); send_byte(8'h44);
      settle("R9");
      // R9: inside limits (20 C)
      temp = 16'h0140;
      bus_reset("R1");
      send_byte(8'hEC); send_byte(8'h44);
      settle("R9");
      chk(!fn_open_o, "R9", fn_open_o, 0);
      // R9: below negative lower limit (-10 C, limits -5..25)
      temp = 16'hFF60; lo_lim = 8'hFB;
      bus_reset("R1");
      expect_ev(4'd4, 8'h01, "R9");
      send_byte(8'hEC);
      settle("R9");

      // R11: reset in the middle of a send
      cur_req = "R11";
      bus_reset("R1");
      send_byte(8'h33);
      for (int i = 0; i < 3; i++) begin
         expect_ev(4'd2, id_ref[i], "R4");
         take_byte();
      end
      bus_reset("R11");
      chk(!tx_vld_o, "R11", tx_vld_o, 0);
      send_byte(8'hCC);
      expect_ev(4'd3, 8'hB4, "R11");
      send_byte(8'hB4);
      settle("R11");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule